// File: doc/BRIEF.md
# Resettable Modulo-2 Token Counter

This block counts event tokens two at a time and can be cleared by a second kind of token. Each token arrives as a one-cycle pulse. A count token moves a single stored phase bit. Every second count token produces a carry pulse. A clear token forces the phase back to zero and produces an acknowledge pulse. The block fits token-driven control fabrics in which events carry no clock meaning of their own but must still be ordered deterministically inside a clocked design.

Each input has a one-place holding slot and a ready line, so the sender can see when another token would be refused. When both slots hold a token in the same cycle, a fair two-way arbiter serves one of them and leaves the other waiting. The waiting token is served in the next cycle. Because only one token is served per cycle, there is never more than one output pulse in a cycle.

Top module: `tok_mod2_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the phase is cleared to zero, both holding slots are emptied, both ready outputs are high in the following cycle and both pulse outputs are low.
- R2: A count token served while the phase is zero produces no output pulse and sets the phase to one.
- R3: A count token served while the phase is one produces a one-cycle `carry_o` pulse and sets the phase to zero. For a lone token sampled at rising edge E, the pulse is visible in the cycle after edge E+1.
- R4: A clear token produces a one-cycle `clr_ack_o` pulse and leaves the phase at zero, whatever the phase was before. The latency is the same as in R3.
- R5: An input token is taken only when its ready output is high. Once a token is taken, that ready output is low from the next cycle until the token has been served. A token offered while ready is low is discarded and has no effect on the phase.
- R6: When a count token and a clear token are waiting in the same cycle, one of them is served and the other is served in the next cycle. After reset the count token wins the first such collision. After each collision, the input that lost it wins the next one. Serving a single waiting token does not change this preference.
- R7: `carry_o` and `clr_ack_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_tok_i | input | 1 | Count token pulse |
| cnt_rdy_o | output | 1 | Count holding slot empty, a token can be taken |
| clr_tok_i | input | 1 | Clear token pulse |
| clr_rdy_o | output | 1 | Clear holding slot empty, a token can be taken |
| carry_o | output | 1 | Pulse on every second counted token |
| clr_ack_o | output | 1 | Pulse confirming a served clear token |

## Verification
The phase bit cannot be seen directly. A wrong phase therefore shows up only at the next count token: a carry appears one token early, or goes missing, two edges after that token is sampled. A corrupted collision preference shows up as the reversed order of acknowledge and carry in the cycles after a simultaneous pair. A slot that takes a token while full, or never empties, shows up as an extra carry, or as a ready line that does not return high one edge after service.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned SRC_CNT = 0;
    localparam int unsigned SRC_CLR = 1;

    typedef enum logic [1:0] {
        SRV_IDLE = 2'd0,
        SRV_CNT  = 2'd1,
        SRV_CLR  = 2'd2
    } srv_e;

    typedef struct packed {
        logic carry;
        logic ack;
    } pulse_t;

    function automatic srv_e pick_src(input logic req_cnt,
                                      input logic req_clr,
                                      input logic fav_clr);
        if (req_cnt && req_clr) return fav_clr ? SRV_CLR : SRV_CNT;
        if (req_cnt)            return SRV_CNT;
        if (req_clr)            return SRV_CLR;
        return SRV_IDLE;
    endfunction

endpackage

// File: rtl/tmc_pend_slot.sv
module tmc_pend_slot (
    input  logic clk,
    input  logic rst,
    input  logic tok_i,
    input  logic take_i,
    output logic rdy_o,
    output logic full_o
);

    logic full_q;

    always_ff @(posedge clk) begin
        if (rst)                    full_q <= 1'b0;
        else if (take_i)            full_q <= 1'b0;
        else if (tok_i && !full_q)  full_q <= 1'b1;
    end

    assign full_o = full_q;
    assign rdy_o  = !full_q;

    // R5: an accepted token closes the slot in the next cycle
    p_close_on_take_r5: assert property (@(posedge clk) disable iff (rst)
        (tok_i && rdy_o && !take_i) |=> !rdy_o);

    // R5: a held token stays until it is served
    p_hold_until_served_r5: assert property (@(posedge clk) disable iff (rst)
        (full_o && !take_i) |=> full_o);

    // R5: service is only given to an occupied slot
    p_serve_only_full_r5: assert property (@(posedge clk) disable iff (rst)
        take_i |-> full_o);

endmodule

// File: rtl/tmc_rr_arb.sv
module tmc_rr_arb
    import tmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_cnt_i,
    input  logic req_clr_i,
    output srv_e srv_o
);

    logic fav_clr_q;

    assign srv_o = pick_src(req_cnt_i, req_clr_i, fav_clr_q);

    always_ff @(posedge clk) begin
        if (rst)
            fav_clr_q <= 1'b0;
        else if (req_cnt_i && req_clr_i)
            fav_clr_q <= (srv_o == SRV_CNT);
    end

    // R6: the count side that lost a collision is served next cycle
    p_cnt_loser_next_r6: assert property (@(posedge clk) disable iff (rst)
        (req_cnt_i && req_clr_i && srv_o == SRV_CLR) |=> (srv_o == SRV_CNT));

    // R6: the clear side that lost a collision is served next cycle
    p_clr_loser_next_r6: assert property (@(posedge clk) disable iff (rst)
        (req_cnt_i && req_clr_i && srv_o == SRV_CNT) |=> (srv_o == SRV_CLR));

    // R6: a pending request is never left idle
    p_no_idle_with_req_r6: assert property (@(posedge clk) disable iff (rst)
        (req_cnt_i || req_clr_i) |-> (srv_o != SRV_IDLE));

endmodule

// File: rtl/tmc_parity_core.sv
module tmc_parity_core
    import tmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  srv_e   srv_i,
    output pulse_t out_o
);

    logic   phase_q;
    pulse_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            out_q   <= '0;
        end else begin
            out_q <= '0;
            unique case (srv_i)
                SRV_CNT: begin
                    if (phase_q) begin
                        out_q.carry <= 1'b1;
                        phase_q     <= 1'b0;
                    end else begin
                        phase_q     <= 1'b1;
                    end
                end
                SRV_CLR: begin
                    out_q.ack <= 1'b1;
                    phase_q   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign out_o = out_q;

    // R2: first token of a pair is silent and arms the phase
    p_first_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (srv_i == SRV_CNT && !phase_q) |=> (out_o == '0 && phase_q));

    // R3: second token of a pair carries and disarms
    p_pair_carries_r3: assert property (@(posedge clk) disable iff (rst)
        (srv_i == SRV_CNT && phase_q) |=> (out_o.carry && !phase_q));

    // R4: clear always acknowledges and leaves the phase at zero
    p_clear_acks_r4: assert property (@(posedge clk) disable iff (rst)
        (srv_i == SRV_CLR) |=> (out_o.ack && !out_o.carry && !phase_q));

endmodule

// File: rtl/tok_mod2_counter.sv
module tok_mod2_counter
    import tmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_tok_i,
    output logic cnt_rdy_o,
    input  logic clr_tok_i,
    output logic clr_rdy_o,
    output logic carry_o,
    output logic clr_ack_o
);

    logic [NUM_SRC-1:0] tok_v;
    logic [NUM_SRC-1:0] rdy_v;
    logic [NUM_SRC-1:0] full_v;
    logic [NUM_SRC-1:0] take_v;
    srv_e               srv;
    pulse_t             pulses;

    assign tok_v[SRC_CNT]  = cnt_tok_i;
    assign tok_v[SRC_CLR]  = clr_tok_i;
    assign take_v[SRC_CNT] = (srv == SRV_CNT);
    assign take_v[SRC_CLR] = (srv == SRV_CLR);

    generate
        for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_slot
            tmc_pend_slot u_slot (
                .clk    (clk),
                .rst    (rst),
                .tok_i  (tok_v[gi]),
                .take_i (take_v[gi]),
                .rdy_o  (rdy_v[gi]),
                .full_o (full_v[gi])
            );
        end
    endgenerate

    tmc_rr_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req_cnt_i (full_v[SRC_CNT]),
        .req_clr_i (full_v[SRC_CLR]),
        .srv_o     (srv)
    );

    tmc_parity_core u_core (
        .clk   (clk),
        .rst   (rst),
        .srv_i (srv),
        .out_o (pulses)
    );

    assign cnt_rdy_o = rdy_v[SRC_CNT];
    assign clr_rdy_o = rdy_v[SRC_CLR];
    assign carry_o   = pulses.carry;
    assign clr_ack_o = pulses.ack;

    // R7: never two output pulses in one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        !(carry_o && clr_ack_o));

    // R1: leaving reset the block is idle and open
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt_rdy_o && clr_rdy_o && !carry_o && !clr_ack_o));

endmodule

// File: tb/tok_mod2_counter_tb.sv
module tok_mod2_counter_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_tok = 1'b0;
    logic clr_tok = 1'b0;
    logic cnt_rdy, clr_rdy, carry, ack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tok_mod2_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_tok_i (cnt_tok),
        .cnt_rdy_o (cnt_rdy),
        .clr_tok_i (clr_tok),
        .clr_rdy_o (clr_rdy),
        .carry_o   (carry),
        .clr_ack_o (ack)
    );

    // {count token, clear token, carry 1st, ack 1st, carry 2nd, ack 2nd}
    localparam logic [5:0] VEC [14] = '{
        6'b10_00_00,  // phase 0 -> 1
        6'b10_10_00,  // carry
        6'b01_01_00,  // clear in phase 0
        6'b10_00_00,  // phase 1
        6'b11_10_01,  // collision, count favoured
        6'b10_00_00,  // phase 1
        6'b11_01_00,  // collision, clear favoured
        6'b10_10_00,  // carry
        6'b11_00_01,  // collision, count favoured from phase 0
        6'b01_01_00,  // lone clear keeps preference
        6'b11_01_00,  // collision, clear favoured
        6'b01_01_00,  // clear from phase 1
        6'b10_00_00,
        6'b10_10_00
    };

    task automatic chk(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // drive a token pair, then sample the two following output cycles
    task automatic send(input logic a, input logic r, input string req,
                        input logic [1:0] exp1, input logic [1:0] exp2);
        @(negedge clk); cnt_tok = a; clr_tok = r;
        @(negedge clk); cnt_tok = 1'b0; clr_tok = 1'b0;
        @(negedge clk); chk(req, "first out {carry,ack}", {carry, ack}, exp1);
        @(negedge clk); chk(req, "second out {carry,ack}", {carry, ack}, exp2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", {cnt_rdy, clr_rdy}, 2'b11);
        chk("R1", "outputs after reset", {carry, ack}, 2'b00);

        for (int i = 0; i < 14; i++) begin
            string tag;
            if (VEC[i][5] && VEC[i][4]) tag = "R6";
            else if (VEC[i][4])         tag = "R4";
            else if (VEC[i][3])         tag = "R3";
            else                        tag = "R2";
            send(VEC[i][5], VEC[i][4], tag, VEC[i][3:2], VEC[i][1:0]);
        end

        // R5: second back-to-back count token is refused and ignored
        @(negedge clk); cnt_tok = 1'b1;
        @(negedge clk);
        chk("R5", "count ready while held", {1'b0, cnt_rdy}, 2'b00);
        @(negedge clk); cnt_tok = 1'b0;
        chk("R5", "no output after first token", {carry, ack}, 2'b00);
        @(negedge clk);
        chk("R5", "ready back after service", {1'b0, cnt_rdy}, 2'b01);
        send(1'b1, 1'b0, "R5", 2'b10, 2'b00);

        // R6/R5: collision loser keeps its slot closed for one more cycle
        @(negedge clk); cnt_tok = 1'b1; clr_tok = 1'b1;
        @(negedge clk); cnt_tok = 1'b0; clr_tok = 1'b0;
        @(negedge clk);
        chk("R6", "count wins, silent", {carry, ack}, 2'b00);
        chk("R6", "loser clear still held", {cnt_rdy, clr_rdy}, 2'b10);
        @(negedge clk);
        chk("R6", "clear served next", {carry, ack}, 2'b01);

        // R1: mid-run reset clears an armed phase
        send(1'b1, 1'b0, "R2", 2'b00, 2'b00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after mid reset", {cnt_rdy, clr_rdy}, 2'b11);
        send(1'b1, 1'b0, "R1", 2'b00, 2'b00);
        send(1'b1, 1'b0, "R1", 2'b10, 2'b00);

        // R1: reset discards a held token
        @(negedge clk); cnt_tok = 1'b1;
        @(negedge clk); cnt_tok = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "held token dropped", {carry, ack}, 2'b00);
        @(negedge clk);
        chk("R1", "still quiet", {carry, ack}, 2'b00);
        send(1'b1, 1'b0, "R1", 2'b00, 2'b00);
        send(1'b1, 1'b0, "R7", 2'b10, 2'b00);

        finish_run();
    end

endmodule